// File: doc/BRIEF.md
# Boost Converter Startup and Fault Sequencer

This block is the digital supervisor that brings a boost converter up from an idle condition and keeps it safe once running. It reads a handful of comparator flags from the analog side and decides, cycle by cycle, which operating stage the converter is in. The stages are: off, two linear precharge stages at rising current, a soft-start ramp of the internal reference, steady boost regulation, pass-through bypass, and a timed fault hold. On the way up it drives the precharge current select, the switching enable and a reference step strobe. On the way down it raises a fault flag and keeps the power stage quiet.

Every stage has a time limit counted on a reference clock. If a precharge stage, the soft-start window or a sustained overload runs out, the block enters a fault state. There it waits a fixed restart interval and then tries again from the first precharge stage. Losing the enable or the undervoltage-lockout flag drops the block to the off state from anywhere, at the next clock. A fast-start select halves both precharge limits and the soft-start step interval.

Top module: `boost_seq_top`

## Requirements
- R1: When `en_i` or `uvlo_ok_i` is low at a clock edge, the state after that edge is OFF (code 0) from any state. OFF drives `pre_lvl_o`=0, `sw_en_o`=0, `ref_step_o`=0 and `fault_o`=0. Reset also gives OFF.
- R2: From OFF, with `en_i` and `uvlo_ok_i` both high, the next state is PRE1 (code 1). PRE1 drives `pre_lvl_o`=1 (the low current level).
- R3: In PRE1, `near_in_i` high moves the block to RAMP (code 3) at the next edge. Otherwise the block leaves PRE1 for PRE2 (code 2) after exactly T_PRE1 cycles in PRE1.
- R4: PRE2 drives `pre_lvl_o`=2 (the high current level). In PRE2, `near_in_i` high moves the block to RAMP. Otherwise the block moves to FAULT (code 6) after exactly T_PRE2 cycles in PRE2.
- R5: RAMP drives `sw_en_o`=1 and pulses `ref_step_o` for one cycle at the end of every STEP_CYC cycles, for RAMP_STEPS pulses. After the last pulse the block moves to FAULT if `at_target_i` has not been seen high within T_SSWIN cycles.
- R6: In RAMP after the last step, `at_target_i` high selects BYPASS (code 5) when `vin_above_i` is high, and BOOST (code 4) otherwise.
- R7: BOOST drives `sw_en_o`=1 and enters FAULT on the T_OVLD-th consecutive cycle with `ilim_i` high. A shorter run of `ilim_i`, followed by a low cycle, does not cause a fault.
- R8: FAULT drives `fault_o`=1, `sw_en_o`=0 and `pre_lvl_o`=0. After exactly T_RESTART cycles in FAULT, the block returns to PRE1.
- R9: BYPASS drives `sw_en_o`=0 and `pre_lvl_o`=0. When `vin_above_i` goes low, the block moves to BOOST at the next edge.
- R10: With `fast_i` high, PRE1 lasts T_PRE1/2 cycles, PRE2 lasts T_PRE2/2 cycles and the ramp step interval is STEP_CYC/2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock for all timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| uvlo_ok_i | input | 1 | Input supply above lockout threshold |
| near_in_i | input | 1 | Output within precharge margin of input |
| at_target_i | input | 1 | Output at regulation target |
| vin_above_i | input | 1 | Input above regulation target |
| ilim_i | input | 1 | Switch current limit active |
| fast_i | input | 1 | Fast-start select (halves precharge and step timing) |
| state_o | output | 3 | Stage code: 0 OFF, 1 PRE1, 2 PRE2, 3 RAMP, 4 BOOST, 5 BYPASS, 6 FAULT |
| pre_lvl_o | output | 2 | Precharge current: 0 none, 1 low, 2 high |
| sw_en_o | output | 1 | Modulator switching enable |
| ref_step_o | output | 1 | One-cycle strobe to step the internal reference |
| fault_o | output | 1 | Fault hold indication |

## Verification
The soft-start window fault is the hardest case to reach. It needs the block to pass both precharge checks and run out the whole reference ramp, and then see the target comparator stay low for the full window. A single late rise of the flag would take the block to boost instead. The stimulus gets there by raising `near_in_i` while in the second precharge stage and then holding `at_target_i` low. A separate pass raises `at_target_i` only after the last step, so both exits from the ramp are covered. A behavioural model follows every cycle and checks the overload counter: it checks that a burst shorter than the limit is forgotten, and that a sustained one trips on the exact cycle.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_PRE1 = 3'd1,
    ST_PRE2 = 3'd2,
    ST_RAMP = 3'd3,
    ST_BST  = 3'd4,
    ST_BYP  = 3'd5,
    ST_FLT  = 3'd6
  } seq_state_e;

  // Fast start halves a duration.
  function automatic int unsigned scale_len(input int unsigned len, input logic fast);
    return fast ? (len >> 1) : len;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int unsigned cyc_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/boost_seq_timer.sv
module boost_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  // Saturating up-counter, synchronously cleared.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (cnt_o != '1)       cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/boost_seq_ramp.sv
module boost_seq_ramp
  import boost_seq_pkg::*;
#(
  parameter int unsigned RAMP_STEPS = 8,
  parameter int unsigned STEP_CYC   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic fast_i,
  output logic step_o,
  output logic done_o
);

  localparam int unsigned PH_W = cyc_bits(STEP_CYC);
  localparam int unsigned K_W  = cyc_bits(RAMP_STEPS);

  logic [PH_W-1:0] ph_q;
  logic [K_W-1:0]  k_q;
  logic [PH_W-1:0] ph_last;

  assign ph_last = PH_W'(scale_len(STEP_CYC, fast_i) - 1);
  assign done_o  = (k_q == K_W'(RAMP_STEPS));
  assign step_o  = run_i && !done_o && (ph_q == ph_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      k_q  <= '0;
    end else if (!run_i) begin
      ph_q <= '0;
      k_q  <= '0;
    end else if (!done_o) begin
      if (ph_q == ph_last) begin
        ph_q <= '0;
        k_q  <= k_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // R5: strobes are single-cycle pulses spaced by the step interval
  a_r5_step_single: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);

endmodule

// File: rtl/boost_seq_fsm.sv
module boost_seq_fsm
  import boost_seq_pkg::*;
#(
  parameter int unsigned T_PRE1    = 512,
  parameter int unsigned T_PRE2    = 1024,
  parameter int unsigned T_SSWIN   = 64,
  parameter int unsigned T_OVLD    = 2000,
  parameter int unsigned T_RESTART = 20000,
  parameter int unsigned CNT_W     = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             uvlo_ok_i,
  input  logic             near_in_i,
  input  logic             at_target_i,
  input  logic             vin_above_i,
  input  logic             ilim_i,
  input  logic             fast_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ramp_done_i,
  output seq_state_e       state_o,
  output logic             timer_clr_o,
  output logic [1:0]       pre_lvl_o,
  output logic             sw_en_o,
  output logic             fault_o
);

  seq_state_e state_q, state_n;

  // Named events for the assertions and for readability
  logic go_down, pre1_expire, pre2_expire, win_expire, ovld_expire, rst_expire;

  assign go_down     = !en_i || !uvlo_ok_i;
  assign pre1_expire = (cnt_i == CNT_W'(scale_len(T_PRE1, fast_i) - 1));
  assign pre2_expire = (cnt_i == CNT_W'(scale_len(T_PRE2, fast_i) - 1));
  assign win_expire  = ramp_done_i && (cnt_i == CNT_W'(T_SSWIN - 1));
  assign ovld_expire = ilim_i && (cnt_i == CNT_W'(T_OVLD - 1));
  assign rst_expire  = (cnt_i == CNT_W'(T_RESTART - 1));

  always_comb begin
    state_n = state_q;
    if (go_down) begin
      state_n = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_n = ST_PRE1;
        ST_PRE1: if (near_in_i) state_n = ST_RAMP; else if (pre1_expire) state_n = ST_PRE2;
        ST_PRE2: if (near_in_i) state_n = ST_RAMP; else if (pre2_expire) state_n = ST_FLT;
        ST_RAMP: begin
          if (ramp_done_i && at_target_i) state_n = vin_above_i ? ST_BYP : ST_BST;
          else if (win_expire)            state_n = ST_FLT;
        end
        ST_BST:  if (ovld_expire) state_n = ST_FLT;
        ST_BYP:  if (!vin_above_i) state_n = ST_BST;
        ST_FLT:  if (rst_expire) state_n = ST_PRE1;
        default: state_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_n;
  end

  // Timer restarts on every stage change; in RAMP it waits for the ramp end,
  // in BOOST it counts only consecutive current-limit cycles.
  assign timer_clr_o = (state_n != state_q)
                     || (state_q == ST_RAMP && !ramp_done_i)
                     || (state_q == ST_BST  && !ilim_i);

  assign state_o   = state_q;
  assign pre_lvl_o = (state_q == ST_PRE1) ? 2'd1 : (state_q == ST_PRE2) ? 2'd2 : 2'd0;
  assign sw_en_o   = (state_q == ST_RAMP) || (state_q == ST_BST);
  assign fault_o   = (state_q == ST_FLT);

  // R1: lost enable or lockout forces OFF at the next edge
  a_r1_off_next: assert property (@(posedge clk) disable iff (!rst_n)
    go_down |=> state_q == ST_OFF);

  // R2: a qualified start always enters the first precharge stage
  a_r2_start_pre1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !go_down) |=> state_q == ST_PRE1);

  // R3: PRE1 can only hold, step to PRE2, go to RAMP or drop to OFF
  a_r3_pre1_exits: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PRE1 |=> state_q inside {ST_PRE1, ST_PRE2, ST_RAMP, ST_OFF});

  // R5: the ramp is never cut short while the supply stays qualified
  a_r5_ramp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RAMP && !ramp_done_i && !go_down) |=> state_q == ST_RAMP);

  // R7: no overload fault from BOOST without the current limit
  a_r7_ovld_needs_ilim: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BST && !ilim_i) |=> state_q != ST_FLT);

  // R8: a fault hold only ends by restart or shutdown
  a_r8_fault_exit: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FLT |=> state_q inside {ST_FLT, ST_PRE1, ST_OFF});

endmodule

// File: rtl/boost_seq_top.sv
module boost_seq_top
  import boost_seq_pkg::*;
#(
  parameter int unsigned T_PRE1     = 512,
  parameter int unsigned T_PRE2     = 1024,
  parameter int unsigned T_SSWIN    = 64,
  parameter int unsigned T_OVLD     = 2000,
  parameter int unsigned T_RESTART  = 20000,
  parameter int unsigned RAMP_STEPS = 8,
  parameter int unsigned STEP_CYC   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       uvlo_ok_i,
  input  logic       near_in_i,
  input  logic       at_target_i,
  input  logic       vin_above_i,
  input  logic       ilim_i,
  input  logic       fast_i,
  output logic [2:0] state_o,
  output logic [1:0] pre_lvl_o,
  output logic       sw_en_o,
  output logic       ref_step_o,
  output logic       fault_o
);

  localparam int unsigned CNT_MAX = max2(max2(T_PRE1, T_PRE2),
                                         max2(max2(T_SSWIN, T_OVLD), T_RESTART));
  localparam int unsigned CNT_W   = cyc_bits(CNT_MAX);

  logic [CNT_W-1:0] cnt;
  logic             timer_clr;
  logic             ramp_done;
  seq_state_e       state;

  boost_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (timer_clr),
    .cnt_o (cnt)
  );

  boost_seq_ramp #(.RAMP_STEPS(RAMP_STEPS), .STEP_CYC(STEP_CYC)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (state == ST_RAMP),
    .fast_i (fast_i),
    .step_o (ref_step_o),
    .done_o (ramp_done)
  );

  boost_seq_fsm #(
    .T_PRE1(T_PRE1), .T_PRE2(T_PRE2), .T_SSWIN(T_SSWIN),
    .T_OVLD(T_OVLD), .T_RESTART(T_RESTART), .CNT_W(CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .uvlo_ok_i   (uvlo_ok_i),
    .near_in_i   (near_in_i),
    .at_target_i (at_target_i),
    .vin_above_i (vin_above_i),
    .ilim_i      (ilim_i),
    .fast_i      (fast_i),
    .cnt_i       (cnt),
    .ramp_done_i (ramp_done),
    .state_o     (state),
    .timer_clr_o (timer_clr),
    .pre_lvl_o   (pre_lvl_o),
    .sw_en_o     (sw_en_o),
    .fault_o     (fault_o)
  );

  assign state_o = state;

endmodule

// File: tb/boost_seq_top_tb.sv
`timescale 1ns/100ps
module boost_seq_top_tb;

  localparam int L1 = 16, L2 = 32, WIN = 8, OV = 20, RS = 40, NST = 4, PER = 6;

  logic clk = 0, rst_n = 0;
  logic en = 0, uvlo = 0, near = 0, at = 0, vab = 0, ilim = 0, fast = 0;
  logic [2:0] state;
  logic [1:0] pre;
  logic sw, step, flt;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  boost_seq_top #(
    .T_PRE1(L1), .T_PRE2(L2), .T_SSWIN(WIN), .T_OVLD(OV), .T_RESTART(RS),
    .RAMP_STEPS(NST), .STEP_CYC(PER)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .uvlo_ok_i(uvlo), .near_in_i(near),
    .at_target_i(at), .vin_above_i(vab), .ilim_i(ilim), .fast_i(fast),
    .state_o(state), .pre_lvl_o(pre), .sw_en_o(sw), .ref_step_o(step), .fault_o(flt)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int ms = 0, age = 0, run = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; age = 0; run = 0;
    end else begin
      int nx, l1, l2, ramp;
      l1 = fast ? L1 / 2 : L1;
      l2 = fast ? L2 / 2 : L2;
      ramp = NST * (fast ? PER / 2 : PER);
      nx = ms;
      if (!en || !uvlo) nx = 0;
      else case (ms)
        0: nx = 1;
        1: if (near) nx = 3; else if (age + 1 >= l1) nx = 2;
        2: if (near) nx = 3; else if (age + 1 >= l2) nx = 6;
        3: if (age >= ramp) begin
             if (at) nx = vab ? 5 : 4;
             else if (age - ramp + 1 >= WIN) nx = 6;
           end
        4: if (ilim && run + 1 >= OV) nx = 6;
        5: if (!vab) nx = 4;
        6: if (age + 1 >= RS) nx = 1;
        default: nx = 0;
      endcase
      if (nx != ms) begin age = 0; run = 0; end
      else begin age++; run = ilim ? run + 1 : 0; end
      ms = nx;
    end
  end

  function automatic string tag_of(input int s);
    case (s)
      0: return "R1"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R7"; 5: return "R9"; default: return "R8";
    endcase
  endfunction

  // Compare every cycle: {state, pre, sw, step, fault}
  always @(negedge clk) begin
    if (rst_n) begin
      int p, exp_v, act_v;
      logic es;
      p = fast ? PER / 2 : PER;
      es = (ms == 3) && (age < NST * p) && (age % p == p - 1);
      exp_v = {ms[2:0], (ms == 1) ? 2'd1 : (ms == 2) ? 2'd2 : 2'd0,
               (ms == 3 || ms == 4), es, (ms == 6)};
      act_v = {state, pre, sw, step, flt};
      check({tag_of(ms), " model"}, act_v, exp_v);
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_state(input int exp, input int maxc, input string tag, output int waited);
    waited = 0;
    while (state != exp[2:0] && waited < maxc) begin cyc(1); waited++; end
    check(tag, state, exp);
  endtask

  initial begin
    #(5.0 * 20000);
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w, nsteps;
    cyc(3); rst_n = 1; cyc(2);
    check("R1 reset state", state, 0);
    en = 1; uvlo = 1; cyc(1);
    check("R2 enter PRE1", state, 1);
    check("R2 low level", pre, 1);
    cyc(4); near = 1;
    wait_state(3, 3, "R3 near_in to RAMP", w); near = 0;
    nsteps = 0;
    for (int i = 0; i < 28; i++) begin nsteps += step; check("R5 sw_en in RAMP", sw, 1); cyc(1); end
    check("R5 step count", nsteps, NST);
    at = 1;
    wait_state(4, 3, "R6 RAMP to BOOST", w);
    ilim = 1; cyc(10); ilim = 0; cyc(2);
    check("R7 short burst ignored", state, 4);
    ilim = 1;
    wait_state(6, OV + 3, "R7 overload fault", w);
    check("R7 overload length", w, OV);
    ilim = 0; at = 0;
    check("R8 fault flag", flt, 1);
    check("R8 no switching", sw, 0);
    wait_state(1, RS + 3, "R8 restart", w);
    check("R8 restart length", w, RS);
    wait_state(2, L1 + 3, "R3 PRE1 timeout", w);
    check("R3 PRE1 length", w, L1);
    check("R4 high level", pre, 2);
    wait_state(6, L2 + 3, "R4 PRE2 timeout", w);
    check("R4 PRE2 length", w, L2);
    en = 0; cyc(1);
    check("R1 enable low in FAULT", state, 0);
    en = 1;
    wait_state(1, 3, "R2 re-enter", w);
    wait_state(2, L1 + 3, "R3 PRE1 timeout again", w);
    near = 1;
    wait_state(3, 3, "R4 near_in to RAMP", w); near = 0;
    wait_state(6, NST * PER + WIN + 3, "R5 window fault", w);
    check("R5 window length", w, NST * PER + WIN);
    wait_state(1, RS + 3, "R8 restart again", w);
    near = 1;
    wait_state(3, 3, "R3 to RAMP", w); near = 0;
    vab = 1; at = 1;
    wait_state(5, NST * PER + 3, "R6 RAMP to BYPASS", w);
    check("R9 no switching in BYPASS", sw, 0);
    vab = 0;
    wait_state(4, 3, "R9 BYPASS to BOOST", w);
    uvlo = 0; cyc(1);
    check("R1 lockout in BOOST", state, 0);
    at = 0; en = 0; uvlo = 1; fast = 1; cyc(1);
    en = 1;
    wait_state(1, 3, "R10 start", w);
    wait_state(2, L1, "R10 fast PRE1", w);
    check("R10 fast PRE1 length", w, L1 / 2);
    wait_state(6, L2, "R10 fast PRE2", w);
    check("R10 fast PRE2 length", w, L2 / 2);
    en = 0; cyc(1); en = 1; near = 1;
    wait_state(3, 4, "R10 fast to RAMP", w); near = 0;
    nsteps = 0;
    for (int i = 0; i < 12; i++) begin nsteps += step; cyc(1); end
    check("R10 fast step count", nsteps, 4);
    cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule